// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block is a clocked sequencer that lets on-chip logic read and write an external asynchronous static RAM. A host issues one request at a time over a valid/ready port: a write or read flag, a word address and, for writes, a data word. The controller drives the memory's active-low chip select, output enable and write enable, holds the address steady for the whole access, and shares one bidirectional data bus with the memory.

Every access is split into phases, and each phase lasts a cycle count taken from a configuration input. A count of zero is treated as one cycle. A read selects the chip, waits out the setup phase, and then opens the memory's output drivers for the access phase. It samples the bus on the last access cycle and returns the word with a one-cycle valid pulse. The read ends with a float phase in which the chip is deselected, so the memory's drivers have time to reach high impedance. A write selects the chip and waits out the setup phase. It lowers write enable for a gap phase while the bus stays undriven, then drives the data for the data phase. It raises write enable and keeps driving the data through the hold phase, and only then releases the bus.

Top module: `asram_ctrl`

## Requirements
- R1: During and right after reset, `mem_cs_n`, `mem_oe_n` and `mem_we_n` are high, `req_ready` is 1, `rvalid` is 0 and the controller does not drive `mem_dq`.
- R2: `req_ready` is 1 only while the controller is idle with the chip deselected. A request is taken only on a cycle where `req_valid` and `req_ready` are both 1. A request raised while busy has no effect on the running access or on memory contents.
- R3: `mem_oe_n` and `mem_we_n` are never low together, and `mem_oe_n` is low only while `mem_cs_n` is low.
- R4: A read (`req_we`=0) holds `mem_cs_n` low with `mem_oe_n` high for `cfg_setup` cycles. It then holds `mem_oe_n` low for `cfg_access` cycles.
- R5: After a read's access phase, all strobes stay high for `cfg_float` cycles before `req_ready` returns. The read occupies `cfg_setup`+`cfg_access`+`cfg_float` cycles with `req_ready` low.
- R6: A write (`req_we`=1) holds `mem_cs_n` low with both enables high for `cfg_setup` cycles, then `mem_we_n` low for `cfg_float`+`cfg_wdata` cycles, then `mem_we_n` high with the chip still selected for `cfg_hold` cycles. Its busy time is the sum of those four counts.
- R7: The controller drives `mem_dq` only while `mem_cs_n` is low and `mem_oe_n` is high. It drives it during the write data and hold phases, so the data is valid when `mem_we_n` rises.
- R8: Any configuration count of 0 behaves as a count of 1.
- R9: `mem_addr` stays stable for the whole time `mem_cs_n` is low and equals the accepted `addr`.
- R10: `rvalid` is a single-cycle pulse, raised only by a read, in the first cycle after the access phase. `rdata` then holds the bus value sampled on the last access cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller idle, request may be taken |
| req_we | input | 1 | 1 = write, 0 = read |
| addr | input | AW | Word address |
| wdata | input | DW | Write data |
| rvalid | output | 1 | One-cycle read result strobe |
| rdata | output | DW | Read result |
| cfg_setup | input | CW | Cycles of chip select before an enable falls |
| cfg_access | input | CW | Cycles of output enable low on a read |
| cfg_float | input | CW | Bus turnaround cycles (read float, write gap) |
| cfg_wdata | input | CW | Cycles the write data is driven with write enable low |
| cfg_hold | input | CW | Cycles the data is held after write enable rises |
| mem_cs_n | output | 1 | Memory chip select, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_addr | output | AW | Memory address |
| mem_dq | inout | DW | Shared data bus |

## Verification
A phase sequencer stuck in, or skipping, a state shows up within one access. The busy time seen on `req_ready` and the low times of the three strobes no longer add up to the configured counts. A wrong turnaround order appears in the same cycle as both enables low, or as the controller driving the bus under output enable. Bad capture timing or a bad data hold shows up on the read that follows, because the word read back differs from the word written.

// File: rtl/asram_pkg.sv
package asram_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_RD_SETUP,
        PH_RD_ACCESS,
        PH_RD_FLOAT,
        PH_WR_SETUP,
        PH_WR_GAP,
        PH_WR_DATA,
        PH_WR_HOLD
    } phase_e;

    typedef struct packed {
        logic cs_n;
        logic oe_n;
        logic we_n;
        logic drive;
    } strobe_t;

    // Memory-side strobe levels for each phase.
    function automatic strobe_t strobes_of(phase_e ph);
        strobe_t s;
        s = '{cs_n: 1'b1, oe_n: 1'b1, we_n: 1'b1, drive: 1'b0};
        case (ph)
            PH_RD_SETUP:  s.cs_n = 1'b0;
            PH_RD_ACCESS: begin s.cs_n = 1'b0; s.oe_n = 1'b0; end
            PH_WR_SETUP:  s.cs_n = 1'b0;
            PH_WR_GAP:    begin s.cs_n = 1'b0; s.we_n = 1'b0; end
            PH_WR_DATA:   begin s.cs_n = 1'b0; s.we_n = 1'b0; s.drive = 1'b1; end
            PH_WR_HOLD:   begin s.cs_n = 1'b0; s.drive = 1'b1; end
            default:      ;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/asram_phase_timer.sv
module asram_phase_timer #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          last
);
    localparam logic [CW-1:0] ONE = CW'(1);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] eff;

    assign eff  = (load_val == '0) ? ONE : load_val;
    assign last = (cnt_q == ONE);

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= ONE;
        else if (load)
            cnt_q <= eff;
        else if (cnt_q > ONE)
            cnt_q <= cnt_q - ONE;
    end
endmodule

// File: rtl/asram_seq.sv
module asram_seq
    import asram_pkg::*;
#(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    input  logic          req_we,
    input  logic [CW-1:0] cfg_setup,
    input  logic [CW-1:0] cfg_access,
    input  logic [CW-1:0] cfg_float,
    input  logic [CW-1:0] cfg_wdata,
    input  logic [CW-1:0] cfg_hold,
    input  logic          last,
    output logic          load,
    output logic [CW-1:0] load_val,
    output logic          accept,
    output logic          capture,
    output logic          idle,
    output strobe_t       strobes
);
    phase_e ph_q, ph_d;

    always_comb begin
        ph_d     = ph_q;
        load     = 1'b0;
        load_val = '0;
        accept   = 1'b0;
        capture  = 1'b0;
        case (ph_q)
            PH_IDLE: if (req_valid) begin
                accept   = 1'b1;
                load     = 1'b1;
                load_val = cfg_setup;
                ph_d     = req_we ? PH_WR_SETUP : PH_RD_SETUP;
            end
            PH_RD_SETUP: if (last) begin
                load = 1'b1; load_val = cfg_access; ph_d = PH_RD_ACCESS;
            end
            PH_RD_ACCESS: if (last) begin
                capture = 1'b1;
                load = 1'b1; load_val = cfg_float; ph_d = PH_RD_FLOAT;
            end
            PH_RD_FLOAT: if (last) ph_d = PH_IDLE;
            PH_WR_SETUP: if (last) begin
                load = 1'b1; load_val = cfg_float; ph_d = PH_WR_GAP;
            end
            PH_WR_GAP: if (last) begin
                load = 1'b1; load_val = cfg_wdata; ph_d = PH_WR_DATA;
            end
            PH_WR_DATA: if (last) begin
                load = 1'b1; load_val = cfg_hold; ph_d = PH_WR_HOLD;
            end
            PH_WR_HOLD: if (last) ph_d = PH_IDLE;
            default: ph_d = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) ph_q <= PH_IDLE;
        else     ph_q <= ph_d;
    end

    assign idle    = (ph_q == PH_IDLE);
    assign strobes = strobes_of(ph_q);
endmodule

// File: rtl/asram_dpath.sv
module asram_dpath #(
    parameter int AW = 6,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          accept,
    input  logic          capture,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    input  logic [DW-1:0] dq_in,
    output logic [AW-1:0] addr_q,
    output logic [DW-1:0] wdata_q,
    output logic [DW-1:0] rdata,
    output logic          rvalid
);
    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q  <= '0;
            wdata_q <= '0;
            rdata   <= '0;
            rvalid  <= 1'b0;
        end else begin
            rvalid <= capture;
            if (accept) begin
                addr_q  <= addr;
                wdata_q <= wdata;
            end
            if (capture)
                rdata <= dq_in;
        end
    end
endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
    import asram_pkg::*;
#(
    parameter int AW = 6,
    parameter int DW = 16,
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic          req_we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic          rvalid,
    output logic [DW-1:0] rdata,
    input  logic [CW-1:0] cfg_setup,
    input  logic [CW-1:0] cfg_access,
    input  logic [CW-1:0] cfg_float,
    input  logic [CW-1:0] cfg_wdata,
    input  logic [CW-1:0] cfg_hold,
    output logic          mem_cs_n,
    output logic          mem_oe_n,
    output logic          mem_we_n,
    output logic [AW-1:0] mem_addr,
    inout  wire  [DW-1:0] mem_dq
);
    logic          load, last, accept, capture, idle;
    logic [CW-1:0] load_val;
    strobe_t       strobes;
    logic [DW-1:0] wdata_q;
    logic          dq_drive;

    asram_phase_timer #(.CW(CW)) u_timer (
        .clk(clk), .rst(rst), .load(load), .load_val(load_val), .last(last)
    );

    asram_seq #(.CW(CW)) u_seq (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_we(req_we),
        .cfg_setup(cfg_setup), .cfg_access(cfg_access), .cfg_float(cfg_float),
        .cfg_wdata(cfg_wdata), .cfg_hold(cfg_hold), .last(last),
        .load(load), .load_val(load_val), .accept(accept), .capture(capture),
        .idle(idle), .strobes(strobes)
    );

    asram_dpath #(.AW(AW), .DW(DW)) u_dpath (
        .clk(clk), .rst(rst), .accept(accept), .capture(capture),
        .addr(addr), .wdata(wdata), .dq_in(mem_dq),
        .addr_q(mem_addr), .wdata_q(wdata_q), .rdata(rdata), .rvalid(rvalid)
    );

    assign req_ready = idle;
    assign mem_cs_n  = strobes.cs_n;
    assign mem_oe_n  = strobes.oe_n;
    assign mem_we_n  = strobes.we_n;
    assign dq_drive  = strobes.drive;
    assign mem_dq    = dq_drive ? wdata_q : {DW{1'bz}};
endmodule

// File: rtl/asram_ctrl_chk.sv
module asram_ctrl_chk #(
    parameter int AW = 6
) (
    input logic          clk,
    input logic          rst,
    input logic          cs_n,
    input logic          oe_n,
    input logic          we_n,
    input logic          dq_drive,
    input logic          ready,
    input logic          rvalid,
    input logic [AW-1:0] maddr
);
    AST_NO_ENABLE_CLASH: assert property (@(posedge clk) disable iff (rst)
        !(!oe_n && !we_n)); // R3
    AST_OE_NEEDS_CS: assert property (@(posedge clk) disable iff (rst)
        !oe_n |-> !cs_n); // R3
    AST_NO_DRIVE_UNDER_OE: assert property (@(posedge clk) disable iff (rst)
        dq_drive |-> (oe_n && !cs_n)); // R7
    AST_HOLD_DRIVEN: assert property (@(posedge clk) disable iff (rst)
        ($rose(we_n) && !cs_n) |-> dq_drive); // R7
    AST_READY_DESELECTED: assert property (@(posedge clk) disable iff (rst)
        ready |-> (cs_n && oe_n && we_n)); // R2
    AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (rst)
        (!cs_n && $past(!cs_n)) |-> $stable(maddr)); // R9
    AST_RVALID_PULSE: assert property (@(posedge clk) disable iff (rst)
        rvalid |=> !rvalid); // R10
    AST_RVALID_AFTER_OE: assert property (@(posedge clk) disable iff (rst)
        rvalid |-> ($past(!oe_n) && oe_n)); // R10
endmodule

bind asram_ctrl asram_ctrl_chk #(.AW(AW)) u_chk (
    .clk(clk), .rst(rst), .cs_n(mem_cs_n), .oe_n(mem_oe_n), .we_n(mem_we_n),
    .dq_drive(dq_drive), .ready(req_ready), .rvalid(rvalid), .maddr(mem_addr)
);

// File: tb/asram_ctrl_test.sv
module asram_ctrl_test;
    localparam int AW = 6;
    localparam int DW = 16;
    localparam int CW = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic          req_we = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic [CW-1:0] c_s = 1, c_a = 1, c_f = 1, c_w = 1, c_h = 1;
    logic          req_ready, rvalid, cs_n, oe_n, we_n;
    logic [DW-1:0] rdata;
    logic [AW-1:0] maddr;
    wire  [DW-1:0] dq;

    int total = 0;
    int bad = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    asram_ctrl #(.AW(AW), .DW(DW), .CW(CW)) uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_we(req_we), .addr(addr), .wdata(wdata), .rvalid(rvalid), .rdata(rdata),
        .cfg_setup(c_s), .cfg_access(c_a), .cfg_float(c_f), .cfg_wdata(c_w),
        .cfg_hold(c_h), .mem_cs_n(cs_n), .mem_oe_n(oe_n), .mem_we_n(we_n),
        .mem_addr(maddr), .mem_dq(dq)
    );

    // Behavioural memory: drives on read, stores on write-enable rise.
    logic [DW-1:0] mem [1<<AW];
    assign dq = (!cs_n && !oe_n && we_n) ? mem[maddr] : {DW{1'bz}};
    always @(posedge we_n) if (!cs_n) mem[maddr] <= dq;

    typedef struct packed {
        logic          we;
        logic [AW-1:0] a;
        logic [DW-1:0] d;
        logic [CW-1:0] s, ac, f, w, h;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t TBL [NV] = '{
        '{1'b1, 6'd5,  16'hA5A5, 4'd1, 4'd1, 4'd1, 4'd1, 4'd1},
        '{1'b1, 6'd12, 16'h3C3C, 4'd2, 4'd1, 4'd1, 4'd2, 4'd1},
        '{1'b0, 6'd5,  16'hA5A5, 4'd1, 4'd2, 4'd1, 4'd1, 4'd1},
        '{1'b0, 6'd12, 16'h3C3C, 4'd3, 4'd4, 4'd2, 4'd1, 4'd1},
        '{1'b1, 6'd63, 16'hFFFF, 4'd0, 4'd0, 4'd0, 4'd0, 4'd0},
        '{1'b0, 6'd63, 16'hFFFF, 4'd0, 4'd0, 4'd0, 4'd0, 4'd0},
        '{1'b1, 6'd0,  16'h0001, 4'd4, 4'd1, 4'd3, 4'd5, 4'd2},
        '{1'b0, 6'd0,  16'h0001, 4'd2, 4'd5, 4'd3, 4'd1, 4'd1},
        '{1'b1, 6'd5,  16'h1234, 4'd1, 4'd1, 4'd2, 4'd1, 4'd3},
        '{1'b0, 6'd5,  16'h1234, 4'd1, 4'd1, 4'd1, 4'd1, 4'd1}
    };

    function automatic int cl(logic [CW-1:0] v);
        return (v == 0) ? 1 : int'(v);
    endfunction

    task automatic chk(string req, string what, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Per-access measurements
    int m_busy, m_cs, m_oe, m_we, m_lead, m_csh, m_rv;
    logic [DW-1:0] m_rd;

    // Runs one access; optionally raises a stray write request while busy.
    task automatic run(vec_t v, bit inject, logic [AW-1:0] ia, logic [DW-1:0] id);
        bit strobed;
        @(negedge clk);
        req_we = v.we; addr = v.a; wdata = v.d;
        c_s = v.s; c_a = v.ac; c_f = v.f; c_w = v.w; c_h = v.h;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        m_busy = 0; m_cs = 0; m_oe = 0; m_we = 0; m_lead = 0; m_csh = 0; m_rv = 0;
        m_rd = '0; strobed = 0;
        while (!req_ready && m_busy < 200) begin
            m_busy++;
            if (!cs_n) m_cs++; else m_csh++;
            if (!oe_n) m_oe++;
            if (!we_n) m_we++;
            if (!oe_n || !we_n) strobed = 1;
            if (!cs_n && !strobed) m_lead++;
            if (rvalid) begin m_rv++; m_rd = rdata; end
            if (inject && m_busy == 2) begin
                req_valid = 1'b1; req_we = 1'b1; addr = ia; wdata = id;
            end
            if (inject && m_busy == 3) req_valid = 1'b0;
            @(negedge clk);
        end
        req_valid = 1'b0;
    endtask

    task automatic check_vec(vec_t v, string tag);
        if (v.we) begin
            chk("R6", {tag, " write busy"}, m_busy, cl(v.s) + cl(v.f) + cl(v.w) + cl(v.h));
            chk("R6", {tag, " write cs low"}, m_cs, cl(v.s) + cl(v.f) + cl(v.w) + cl(v.h));
            chk("R6", {tag, " write we low"}, m_we, cl(v.f) + cl(v.w));
            chk("R6", {tag, " write setup"}, m_lead, cl(v.s));
            chk("R3", {tag, " write oe low"}, m_oe, 0);
            chk("R10", {tag, " write rvalid"}, m_rv, 0);
        end else begin
            chk("R5", {tag, " read busy"}, m_busy, cl(v.s) + cl(v.ac) + cl(v.f));
            chk("R4", {tag, " read setup"}, m_lead, cl(v.s));
            chk("R4", {tag, " read oe low"}, m_oe, cl(v.ac));
            chk("R5", {tag, " read float"}, m_csh, cl(v.f));
            chk("R3", {tag, " read we low"}, m_we, 0);
            chk("R10", {tag, " rvalid count"}, m_rv, 1);
            chk("R10", {tag, " rdata"}, int'(m_rd), int'(v.d));
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", "cs_n in reset", int'(cs_n), 1);
        chk("R1", "ready in reset", int'(req_ready), 1);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", "cs_n", int'(cs_n), 1);
        chk("R1", "oe_n", int'(oe_n), 1);
        chk("R1", "we_n", int'(we_n), 1);
        chk("R1", "req_ready", int'(req_ready), 1);
        chk("R1", "rvalid", int'(rvalid), 0);
        // R2: request without valid is not taken
        req_we = 1'b0; addr = 6'd3; c_s = 1;
        @(negedge clk);
        chk("R2", "no accept without valid", int'(cs_n), 1);

        // Table walk; zero counts cover R8
        for (int i = 0; i < NV; i++) begin
            run(TBL[i], 1'b0, '0, '0);
            check_vec(TBL[i], $sformatf("vec%0d", i));
            if (TBL[i].s == 0) chk("R8", "zero counts as one", m_busy, TBL[i].we ? 4 : 3);
        end

        // R2: stray write while a read is busy has no effect
        begin
            vec_t w7, r7;
            w7 = '{1'b1, 6'd7, 16'h0707, 4'd1, 4'd1, 4'd1, 4'd1, 4'd1};
            r7 = '{1'b0, 6'd7, 16'h0707, 4'd3, 4'd3, 4'd2, 4'd1, 4'd1};
            run(w7, 1'b0, '0, '0);
            run(r7, 1'b1, 6'd7, 16'hDEAD);
            chk("R2", "busy unchanged by stray request", m_busy, 8);
            chk("R2", "no extra strobe", m_we, 0);
            @(negedge clk);
            chk("R2", "stray request not queued", int'(cs_n), 1);
            run(r7, 1'b0, '0, '0);
            chk("R2", "memory untouched by stray request", int'(m_rd), 16'h0707);
        end

        // R9: address presented matches request across a read
        begin
            vec_t r5;
            r5 = '{1'b0, 6'd63, 16'hFFFF, 4'd2, 4'd2, 4'd1, 4'd1, 4'd1};
            run(r5, 1'b0, '0, '0);
            chk("R9", "address held", int'(maddr), 63);
            check_vec(r5, "addr63");
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            total++; bad++;
            $display("FAIL watchdog expired actual=%0d expected<=20000", cycles);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule